// File: doc/BRIEF.md
# Smart Panel Command Sequencer

The sequencer executes a stream of 12-bit command words for a display panel that keeps its own frame memory and is driven over an 8-bit parallel bus with a register-select line (A0). Each word holds a 3-bit opcode in bits 11:9, the A0 select in bit 8 and an 8-bit payload in bits 7:0. Words arrive over a valid/ready handshake. A word is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.

Command and data words become single bus write cycles. A read cycle captures the panel's data byte into an 11-bit read status register. Other opcodes stall the stream until the next vsync, stall it for a number of milliseconds, raise a one-cycle interrupt pulse, or are consumed with no effect. Every bus cycle uses the same shape: A0 and data are set up, the strobe is pulsed for a fixed width, and then a single hold cycle follows.

Top module: `smart_seq`

## Requirements
- R1: Opcode 1 (bits 11:9 = 3'd1) produces exactly one write strobe on `pnl_wr`. During it, `pnl_a0` equals word bit 8 (0 = panel command, 1 = panel data) and `pnl_dout` equals word bits 7:0.
- R2: A bus cycle keeps `cmd_ready` low for SETUP_CYC+STROBE_W+1 cycles after the word is accepted. The strobe is high in the last STROBE_W of those cycles except the final hold cycle. It first rises SETUP_CYC cycles after acceptance. `pnl_a0` and `pnl_dout` are stable for the whole cycle.
- R3: Opcode 0 produces one read strobe on `pnl_rd`, with `pnl_a0` = word bit 8 (0 = status register, 1 = frame memory). In the last strobe cycle, `rd_status` captures `pnl_din` into bits 7:0, the A0 used into bit 8, `pnl_ok` into bit 9 (status OK) and `cmd_valid` into bit 10 (a next word is waiting). `rd_status` changes only through a read.
- R4: Opcode 2 (frame write start) produces one write cycle with the word's A0 and payload, with the same timing as R2.
- R5: Opcode 3 holds `cmd_ready` low until `vsync` is sampled high. `cmd_ready` returns in the next cycle and no strobe is issued.
- R6: Opcodes 4 and 7 are consumed in one cycle. `cmd_ready` stays high and no strobe, interrupt or `rd_status` change follows.
- R7: Opcode 5 drives `irq` high for exactly the one cycle after acceptance, with no bus activity and no stall.
- R8: Opcode 6 with payload N > 0 holds `cmd_ready` low for N*CYC_PER_MS cycles. With N = 0 it completes in one cycle and `cmd_ready` stays high.
- R9: After reset, `cmd_ready` is high, `pnl_wr`, `pnl_rd` and `irq` are low, and `rd_status` is zero.
- R10: `pnl_wr` and `pnl_rd` are never high together, and `cmd_ready` is low whenever either strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command word is offered |
| cmd_word | input | 12 | Opcode 11:9, A0 8, payload 7:0 |
| cmd_ready | output | 1 | Sequencer takes a word this cycle |
| vsync | input | 1 | Panel vertical sync, active high |
| pnl_din | input | 8 | Data read from the panel |
| pnl_ok | input | 1 | Panel reports a good read |
| pnl_a0 | output | 1 | Register select to the panel |
| pnl_dout | output | 8 | Data driven to the panel |
| pnl_wr | output | 1 | Write strobe, active high |
| pnl_rd | output | 1 | Read strobe, active high |
| irq | output | 1 | Command interrupt pulse |
| rd_status | output | 11 | Captured read result |

## Verification
On every cycle, the assertions check that the strobes are mutually exclusive and blocked while a word can be taken. They also check that A0 and data hold still across a strobe, and that `rd_status` moves only at the end of a read strobe. In addition, they check that the interrupt pulse follows an accepted opcode 5, and that no-ops and zero delays leave the sequencer ready. Only the bench's scenarios can show the exact stall lengths of bus cycles, vsync waits and millisecond delays, along with where the strobe starts and how many cycles it lasts, and the contents captured by reads. These scenarios mix random words with directed corner cases.

// File: rtl/smart_seq.sv
module smart_seq #(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_W   = 3,
  parameter int CYC_PER_MS = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [11:0] cmd_word,
  output logic        cmd_ready,
  input  logic        vsync,
  input  logic [7:0]  pnl_din,
  input  logic        pnl_ok,
  output logic        pnl_a0,
  output logic [7:0]  pnl_dout,
  output logic        pnl_wr,
  output logic        pnl_rd,
  output logic        irq,
  output logic [10:0] rd_status
);
  localparam int CMAX = (SETUP_CYC > STROBE_W) ? SETUP_CYC : STROBE_W;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int MSW  = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_VWAIT, S_DELAY} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [7:0]     ms;
  logic [MSW-1:0] cyc;
  logic           is_rd;
  logic           a0_q;
  logic [7:0]     dout_q;
  logic [10:0]    stat_q;
  logic           irq_q;

  wire [2:0] op  = cmd_word[11:9];
  wire [7:0] pay = cmd_word[7:0];

  assign cmd_ready = (st == S_IDLE);
  assign pnl_a0    = a0_q;
  assign pnl_dout  = dout_q;
  assign pnl_wr    = (st == S_STRB) && !is_rd;
  assign pnl_rd    = (st == S_STRB) && is_rd;
  assign irq       = irq_q;
  assign rd_status = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ms     <= '0;
      cyc    <= '0;
      is_rd  <= 1'b0;
      a0_q   <= 1'b0;
      dout_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          case (op)
            3'd0, 3'd1, 3'd2: begin
              a0_q   <= cmd_word[8];
              dout_q <= pay;
              is_rd  <= (op == 3'd0);
              cnt    <= CW'(SETUP_CYC - 1);
              st     <= S_SETUP;
            end
            3'd3: st <= S_VWAIT;
            3'd5: irq_q <= 1'b1;
            3'd6: if (pay != 8'd0) begin
              ms  <= pay;
              cyc <= '0;
              st  <= S_DELAY;
            end
            default: ;
          endcase
        end
        S_SETUP: if (cnt == '0) begin
          cnt <= CW'(STROBE_W - 1);
          st  <= S_STRB;
        end else cnt <= cnt - 1'b1;
        S_STRB: if (cnt == '0) begin
          st <= S_HOLD;
          if (is_rd) stat_q <= {cmd_valid, pnl_ok, a0_q, pnl_din};
        end else cnt <= cnt - 1'b1;
        S_HOLD:  st <= S_IDLE;
        S_VWAIT: if (vsync) st <= S_IDLE;
        S_DELAY: if (cyc == MSW'(CYC_PER_MS - 1)) begin
          cyc <= '0;
          if (ms == 8'd1) st <= S_IDLE;
          else ms <= ms - 1'b1;
        end else cyc <= cyc + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smart_seq_chk.sv
module smart_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [11:0] cmd_word,
  input logic        cmd_ready,
  input logic        pnl_a0,
  input logic [7:0]  pnl_dout,
  input logic        pnl_wr,
  input logic        pnl_rd,
  input logic        irq,
  input logic [10:0] rd_status
);
  wire take = cmd_valid && cmd_ready;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pnl_wr && pnl_rd));

  // R10
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pnl_wr || pnl_rd) |-> !cmd_ready);

  // R2
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pnl_wr || pnl_rd) && $past(pnl_wr || pnl_rd)) |-> ($stable(pnl_a0) && $stable(pnl_dout)));

  // R3
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_status) |-> $past(pnl_rd));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(take && cmd_word[11:9] == 3'd5));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_word[11:9] == 3'd5) |=> (irq && cmd_ready));

  // R6
  nop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd_word[11:9] == 3'd4 || cmd_word[11:9] == 3'd7)) |=> cmd_ready);

  // R8
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_word[11:9] == 3'd6 && cmd_word[7:0] == 8'd0) |=> cmd_ready);
endmodule

bind smart_seq smart_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .cmd_ready(cmd_ready), .pnl_a0(pnl_a0), .pnl_dout(pnl_dout),
  .pnl_wr(pnl_wr), .pnl_rd(pnl_rd), .irq(irq), .rd_status(rd_status)
);

// File: tb/sim_smart_seq.sv
`timescale 1ns/1ps
module sim_smart_seq;
  localparam int S   = 2;
  localparam int W   = 3;
  localparam int CPM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [11:0] cmd_word = '0;
  logic cmd_ready;
  logic vsync = 1'b0;
  logic [7:0] pnl_din = '0;
  logic pnl_ok = 1'b0;
  logic pnl_a0, pnl_wr, pnl_rd, irq;
  logic [7:0] pnl_dout;
  logic [10:0] rd_status;

  int total = 0;
  int bad = 0;
  logic [10:0] exp_stat = '0;
  bit done = 0;

  always #10 clk = ~clk;

  smart_seq #(.SETUP_CYC(S), .STROBE_W(W), .CYC_PER_MS(CPM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .vsync(vsync), .pnl_din(pnl_din), .pnl_ok(pnl_ok),
    .pnl_a0(pnl_a0), .pnl_dout(pnl_dout), .pnl_wr(pnl_wr), .pnl_rd(pnl_rd),
    .irq(irq), .rd_status(rd_status));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_busy(logic [11:0] w, int k);
    case (w[11:9])
      3'd0, 3'd1, 3'd2: return S + W + 1;
      3'd3: return k;
      3'd6: return int'(w[7:0]) * CPM;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R3 read";
      3'd1: return "R1 write";
      3'd2: return "R4 frame write";
      3'd3: return "R5 vsync wait";
      3'd5: return "R7 interrupt";
      3'd6: return "R8 delay";
      default: return "R6 no-op";
    endcase
  endfunction

  task automatic run(logic [11:0] w, int k, bit keep);
    int busy = 0, wrc = 0, rdc = 0, first = 0, irq1 = 0, bus_bad = 0, both = 0, guard = 0;
    logic [2:0] op = w[11:9];
    string t = tag_of(op);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (guard == 0) begin
        irq1 = irq;
        cmd_valid = keep;
        cmd_word  = 12'h800;
      end
      guard++;
      vsync = 1'b0;
      if (pnl_wr && pnl_rd) both++;
      if (pnl_wr) wrc++;
      if (pnl_rd) rdc++;
      if ((pnl_wr || pnl_rd) && first == 0) first = busy + 1;
      if (cmd_ready || guard > 20000) break;
      busy++;
      if (op <= 3'd2 && (pnl_a0 !== w[8] || (op != 3'd0 && pnl_dout !== w[7:0]))) bus_bad++;
      if (op == 3'd3 && busy == k) vsync = 1'b1;
    end
    cmd_valid = 1'b0;
    chk({t, " stall cycles"}, busy, exp_busy(w, k));
    chk({t, " write strobes"}, wrc, (op == 3'd1 || op == 3'd2) ? W : 0);
    chk({t, " read strobes"}, rdc, (op == 3'd0) ? W : 0);
    chk("R10 strobe overlap", both, 0);
    chk({t, " irq"}, irq1, (op == 3'd5) ? 1 : 0);
    if (op <= 3'd2) begin
      chk("R2 strobe start", first, S + 1);
      chk("R2 a0/data during cycle", bus_bad, 0);
    end
    if (op == 3'd0) exp_stat = {keep, pnl_ok, w[8], pnl_din};
    chk({t, " rd_status"}, rd_status, exp_stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 ready", cmd_ready, 1);
    chk("R9 wr", pnl_wr, 0);
    chk("R9 rd", pnl_rd, 0);
    chk("R9 irq", irq, 0);
    chk("R9 rd_status", rd_status, 0);
    rst_n = 1'b1;

    // directed corner cases
    run({3'd1, 1'b0, 8'h2C}, 0, 0);      // R1 panel command
    run({3'd1, 1'b1, 8'hA5}, 0, 0);      // R1 panel data
    pnl_din = 8'h5A; pnl_ok = 1'b1;
    run({3'd0, 1'b0, 8'h00}, 0, 0);      // R3 status read
    pnl_din = 8'hC3; pnl_ok = 1'b0;
    run({3'd0, 1'b1, 8'h00}, 0, 1);      // R3 frame read, next word waiting
    run({3'd2, 1'b1, 8'h3C}, 0, 0);      // R4
    run({3'd3, 1'b0, 8'h00}, 1, 0);      // R5 shortest wait
    run({3'd3, 1'b0, 8'h00}, 7, 0);      // R5
    run({3'd7, 1'b1, 8'hFF}, 0, 0);      // R6 opcode 7
    run({3'd4, 1'b0, 8'h11}, 0, 0);      // R6 opcode 4
    run({3'd5, 1'b0, 8'h00}, 0, 0);      // R7
    run({3'd6, 1'b0, 8'h00}, 0, 0);      // R8 zero delay
    run({3'd6, 1'b0, 8'h01}, 0, 0);      // R8 one ms
    run({3'd6, 1'b0, 8'h03}, 0, 0);      // R8 three ms

    // constrained random words
    for (int i = 0; i < 80; i++) begin
      logic [11:0] w = 12'($urandom);
      int k = 1 + int'($urandom % 5);
      if (w[11:9] == 3'd6) w[7:0] = 8'($urandom % 3);
      pnl_din = 8'($urandom);
      pnl_ok  = 1'($urandom);
      run(w, k, 1'($urandom % 4 == 0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule